// File: doc/BRIEF.md
# Register-Launched Memory Request Bank

This block lets software reach memory through a small set of bus-master ports that are driven entirely from a register interface. Each port has a control register holding a direction, byte enables and an address. Software sets it first. A later write of a 32-bit word to the port's launch register starts exactly one memory transaction. That transaction uses the attributes held at that moment, and the written word becomes the write data.

Every port drives a request/grant/valid handshake toward memory. A write ends when the grant is seen. A read ends when data qualified by valid comes back, and that data is then held in a readable register. Four identical ports share one register decoder. A status register shows each port's busy flag.

A per-port back-pressure input from memory says it can take only one more request. The port holds a new launch back while that input is high. The crossing between clock domains on the memory side lies outside this block.

Top module: `memreq_bank`

## Requirements
- R1: After reset, every control, captured-data and status register reads zero and no port raises its request.
- R2: Control register of port p sits at byte address 0x00+4p. Bit 31 selects direction (1 = read, 0 = write), bits 23:20 are the byte enables, bits 19:0 the address. Other bits read back as zero. Reads of unmapped or unaligned addresses return zero, and writes to them change nothing.
- R3: A write to address 0x80+4p while port p is idle starts one transaction. The request rises in the cycle after that write. It carries the written word as write data, the control register's byte enables and address, and write strobe equal to the inverse of the direction bit.
- R4: While the request is high and grant is low, the request stays high and write strobe, byte enables, address and write data stay unchanged.
- R5: The request drops in the cycle after a grant. A write transaction completes on that grant.
- R6: A read waits, after its grant, for valid. It then stores the returned word in the register at 0x40+4p and completes. Valid seen before or together with the grant is ignored.
- R7: Bit 0 of the status register at 0x60+4p is high from the launch write until completion. A launch write to a busy port, including one in the completing cycle, is ignored.
- R8: Rewriting the control register during a transaction leaves that transaction's attributes unchanged. The new value applies to the next launch.
- R9: If the back-pressure input is high when a launch would raise the request, the request waits until that input is low.
- R10: Ports are independent. Register writes to one port and handshake inputs of one port never affect another port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 8 | Register write byte address |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 8 | Register read byte address |
| reg_rd_data | output | 32 | Register read data (combinational) |
| mem_req | output | 4 | Per-port request |
| mem_we | output | 4 | Per-port write strobe, high for write |
| mem_be | output | 16 | Per-port byte enables, 4 bits each |
| mem_addr | output | 80 | Per-port address, 20 bits each |
| mem_wdata | output | 128 | Per-port write data, 32 bits each |
| mem_gnt | input | 4 | Per-port grant |
| mem_valid | input | 4 | Per-port read data valid |
| mem_fmo | input | 4 | Per-port "only one more request" warning |
| mem_rdata | input | 128 | Per-port read data, 32 bits each |

## Verification
Two events can fall in the same cycle. One is the grant that ends a transaction and a fresh launch write to the same port. The other is a grant arriving together with a valid pulse on a read. The bench drives each pair on one clock edge. The reference model in the bench predicts that the launch is dropped and the early valid is ignored. It does this because busy is still high in that cycle and a read only listens for valid after its grant. A control-register rewrite while the request waits for grant is also checked: the address on the bus must not move.

// File: rtl/memreq_pkg.sv
package memreq_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned MADDR_W = 20;
  localparam int unsigned BE_W    = 4;
  localparam int unsigned DIR_BIT = 31;
  localparam int unsigned BE_LSB  = 20;

  localparam int unsigned CTRL_BASE = 'h00;
  localparam int unsigned RDAT_BASE = 'h40;
  localparam int unsigned STAT_BASE = 'h60;
  localparam int unsigned RUN_BASE  = 'h80;
  localparam int unsigned STRIDE    = 4;

  typedef struct packed {
    logic               rd;
    logic [BE_W-1:0]    be;
    logic [MADDR_W-1:0] addr;
  } attr_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HOLD = 2'd1,
    PH_REQ  = 2'd2,
    PH_RESP = 2'd3
  } phase_t;

  function automatic attr_t unpack_ctrl(input logic [DATA_W-1:0] w);
    attr_t a;
    a.rd   = w[DIR_BIT];
    a.be   = w[BE_LSB +: BE_W];
    a.addr = w[MADDR_W-1:0];
    return a;
  endfunction

  function automatic logic [DATA_W-1:0] pack_ctrl(input attr_t a);
    logic [DATA_W-1:0] w;
    w = '0;
    w[DIR_BIT]          = a.rd;
    w[BE_LSB +: BE_W]   = a.be;
    w[MADDR_W-1:0]      = a.addr;
    return w;
  endfunction
endpackage

// File: rtl/memreq_regdec.sv
module memreq_regdec
  import memreq_pkg::*;
#(
  parameter int unsigned N_PORTS = 4,
  parameter int unsigned REG_AW  = 8
) (
  input  logic                      wr_en,
  input  logic [REG_AW-1:0]         wr_addr,
  input  logic [REG_AW-1:0]         rd_addr,
  input  logic [N_PORTS*DATA_W-1:0] ctrl_rb,
  input  logic [N_PORTS*DATA_W-1:0] rdat_rb,
  input  logic [N_PORTS-1:0]        busy_rb,
  output logic [N_PORTS-1:0]        ctrl_we,
  output logic [N_PORTS-1:0]        run_we,
  output logic [DATA_W-1:0]         rd_data
);
  for (genvar p = 0; p < N_PORTS; p++) begin : g_wdec
    localparam logic [REG_AW-1:0] CTRL_A = REG_AW'(CTRL_BASE + STRIDE*p);
    localparam logic [REG_AW-1:0] RUN_A  = REG_AW'(RUN_BASE + STRIDE*p);
    assign ctrl_we[p] = wr_en && (wr_addr == CTRL_A);
    assign run_we[p]  = wr_en && (wr_addr == RUN_A);
  end

  always_comb begin
    rd_data = '0;
    for (int p = 0; p < N_PORTS; p++) begin
      if (rd_addr == REG_AW'(CTRL_BASE + STRIDE*p)) rd_data = ctrl_rb[p*DATA_W +: DATA_W];
      if (rd_addr == REG_AW'(RDAT_BASE + STRIDE*p)) rd_data = rdat_rb[p*DATA_W +: DATA_W];
      if (rd_addr == REG_AW'(STAT_BASE + STRIDE*p)) rd_data = DATA_W'(busy_rb[p]);
    end
  end
endmodule

// File: rtl/memreq_engine.sv
module memreq_engine
  import memreq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_we,
  input  logic               run_we,
  input  logic [DATA_W-1:0]  wdata_in,
  output logic [DATA_W-1:0]  ctrl_rb,
  output logic [DATA_W-1:0]  rdat_rb,
  output logic               busy,
  output logic               mem_req,
  output logic               mem_we,
  output logic [BE_W-1:0]    mem_be,
  output logic [MADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic               mem_gnt,
  input  logic               mem_valid,
  input  logic               mem_fmo,
  input  logic [DATA_W-1:0]  mem_rdata
);
  phase_t            ph_q, ph_d;
  attr_t             ctrl_q, snap_q;
  logic [DATA_W-1:0] wdat_q, rdat_q;
  logic              launch, capture;

  always_comb begin
    ph_d    = ph_q;
    launch  = 1'b0;
    capture = 1'b0;
    unique case (ph_q)
      PH_IDLE: if (run_we) begin
        launch = 1'b1;
        ph_d   = mem_fmo ? PH_HOLD : PH_REQ;
      end
      PH_HOLD: if (!mem_fmo) ph_d = PH_REQ;
      PH_REQ:  if (mem_gnt) ph_d = snap_q.rd ? PH_RESP : PH_IDLE;
      PH_RESP: if (mem_valid) begin
        capture = 1'b1;
        ph_d    = PH_IDLE;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= unpack_ctrl(wdata_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      wdat_q <= '0;
    end else if (launch) begin
      snap_q <= ctrl_q;
      wdat_q <= wdata_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdat_q <= '0;
    else if (capture) rdat_q <= mem_rdata;
  end

  assign ctrl_rb   = pack_ctrl(ctrl_q);
  assign rdat_rb   = rdat_q;
  assign busy      = (ph_q != PH_IDLE);
  assign mem_req   = (ph_q == PH_REQ);
  assign mem_we    = ~snap_q.rd;
  assign mem_be    = snap_q.be;
  assign mem_addr  = snap_q.addr;
  assign mem_wdata = wdat_q;
endmodule

// File: rtl/memreq_bank.sv
module memreq_bank
  import memreq_pkg::*;
#(
  parameter int unsigned N_PORTS = 4,
  parameter int unsigned REG_AW  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr_en,
  input  logic [REG_AW-1:0]          reg_wr_addr,
  input  logic [DATA_W-1:0]          reg_wr_data,
  input  logic [REG_AW-1:0]          reg_rd_addr,
  output logic [DATA_W-1:0]          reg_rd_data,
  output logic [N_PORTS-1:0]         mem_req,
  output logic [N_PORTS-1:0]         mem_we,
  output logic [N_PORTS*BE_W-1:0]    mem_be,
  output logic [N_PORTS*MADDR_W-1:0] mem_addr,
  output logic [N_PORTS*DATA_W-1:0]  mem_wdata,
  input  logic [N_PORTS-1:0]         mem_gnt,
  input  logic [N_PORTS-1:0]         mem_valid,
  input  logic [N_PORTS-1:0]         mem_fmo,
  input  logic [N_PORTS*DATA_W-1:0]  mem_rdata
);
  logic [1:0]                rst_pipe;
  logic                      rst_core_n;
  logic [N_PORTS-1:0]        ctrl_we, run_we, busy_rb;
  logic [N_PORTS*DATA_W-1:0] ctrl_rb, rdat_rb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  memreq_regdec #(.N_PORTS(N_PORTS), .REG_AW(REG_AW)) u_dec (
    .wr_en   (reg_wr_en),
    .wr_addr (reg_wr_addr),
    .rd_addr (reg_rd_addr),
    .ctrl_rb (ctrl_rb),
    .rdat_rb (rdat_rb),
    .busy_rb (busy_rb),
    .ctrl_we (ctrl_we),
    .run_we  (run_we),
    .rd_data (reg_rd_data)
  );

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    memreq_engine u_eng (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .ctrl_we   (ctrl_we[p]),
      .run_we    (run_we[p]),
      .wdata_in  (reg_wr_data),
      .ctrl_rb   (ctrl_rb[p*DATA_W +: DATA_W]),
      .rdat_rb   (rdat_rb[p*DATA_W +: DATA_W]),
      .busy      (busy_rb[p]),
      .mem_req   (mem_req[p]),
      .mem_we    (mem_we[p]),
      .mem_be    (mem_be[p*BE_W +: BE_W]),
      .mem_addr  (mem_addr[p*MADDR_W +: MADDR_W]),
      .mem_wdata (mem_wdata[p*DATA_W +: DATA_W]),
      .mem_gnt   (mem_gnt[p]),
      .mem_valid (mem_valid[p]),
      .mem_fmo   (mem_fmo[p]),
      .mem_rdata (mem_rdata[p*DATA_W +: DATA_W])
    );
  end
endmodule

// File: rtl/memreq_bank_chk.sv
module memreq_bank_chk
  import memreq_pkg::*;
#(
  parameter int unsigned N_PORTS = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [N_PORTS-1:0]         mem_req,
  input logic [N_PORTS-1:0]         mem_we,
  input logic [N_PORTS*BE_W-1:0]    mem_be,
  input logic [N_PORTS*MADDR_W-1:0] mem_addr,
  input logic [N_PORTS*DATA_W-1:0]  mem_wdata,
  input logic [N_PORTS-1:0]         mem_gnt,
  input logic [N_PORTS-1:0]         mem_valid,
  input logic [N_PORTS-1:0]         mem_fmo,
  input logic [N_PORTS*DATA_W-1:0]  rdat_rb,
  input logic [N_PORTS-1:0]         busy_rb
);
  for (genvar p = 0; p < N_PORTS; p++) begin : g_chk
    a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req[p] && !mem_gnt[p]) |=> mem_req[p]);

    a_r4_attr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req[p] && !mem_gnt[p]) |=>
        ($stable(mem_addr[p*MADDR_W +: MADDR_W]) && $stable(mem_be[p*BE_W +: BE_W]) &&
         $stable(mem_we[p]) && $stable(mem_wdata[p*DATA_W +: DATA_W])));

    a_r5_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req[p] && mem_gnt[p]) |=> !mem_req[p]);

    a_r6_capture_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rdat_rb[p*DATA_W +: DATA_W]) |-> $past(mem_valid[p]));

    a_r7_busy_covers_req: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req[p] |-> busy_rb[p]);

    a_r9_launch_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req[p]) |-> !$past(mem_fmo[p]));
  end
endmodule

bind memreq_bank memreq_bank_chk #(.N_PORTS(N_PORTS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_be    (mem_be),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_gnt   (mem_gnt),
  .mem_valid (mem_valid),
  .mem_fmo   (mem_fmo),
  .rdat_rb   (rdat_rb),
  .busy_rb   (busy_rb)
);

// File: tb/memreq_bank_test.sv
`timescale 1ns/1ps
module memreq_bank_test;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [7:0]    rd_addr = '0;
  logic [31:0]   rd_data;
  logic [NP-1:0] req, we;
  logic [NP*4-1:0]  be;
  logic [NP*20-1:0] addr;
  logic [NP*32-1:0] wdata;
  logic [NP-1:0] gnt = '0, valid = '0, fmo = '0;
  logic [NP*32-1:0] rdata = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  memreq_bank uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_wr_addr(wr_addr),
    .reg_wr_data(wr_data), .reg_rd_addr(rd_addr), .reg_rd_data(rd_data),
    .mem_req(req), .mem_we(we), .mem_be(be), .mem_addr(addr), .mem_wdata(wdata),
    .mem_gnt(gnt), .mem_valid(valid), .mem_fmo(fmo), .mem_rdata(rdata)
  );

  // Behavioural reference: per-port arrays, phase 0 idle, 1 held back, 2 requesting, 3 awaiting data
  logic        c_dir [NP];
  logic [3:0]  c_be  [NP];
  logic [19:0] c_addr[NP];
  logic        s_dir [NP];
  logic [3:0]  s_be  [NP];
  logic [19:0] s_addr[NP];
  logic [31:0] s_dat [NP];
  logic [31:0] m_rd  [NP];
  int          ph    [NP];

  always @(posedge clk) begin
    for (int p = 0; p < NP; p++) begin
      if (!rst_n) begin
        c_dir[p] = 0; c_be[p] = 0; c_addr[p] = 0; s_dir[p] = 0; s_be[p] = 0;
        s_addr[p] = 0; s_dat[p] = 0; m_rd[p] = 0; ph[p] = 0;
      end else begin
        case (ph[p])
          0: if (wr_en && wr_addr == 8'h80 + 8'(4*p)) begin
               s_dir[p] = c_dir[p]; s_be[p] = c_be[p]; s_addr[p] = c_addr[p];
               s_dat[p] = wr_data; ph[p] = fmo[p] ? 1 : 2;
             end
          1: if (!fmo[p]) ph[p] = 2;
          2: if (gnt[p]) ph[p] = s_dir[p] ? 3 : 0;
          3: if (valid[p]) begin m_rd[p] = rdata[p*32 +: 32]; ph[p] = 0; end
          default: ph[p] = 0;
        endcase
        if (wr_en && wr_addr == 8'(4*p)) begin
          c_dir[p] = wr_data[31]; c_be[p] = wr_data[23:20]; c_addr[p] = wr_data[19:0];
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int p = 0; p < NP; p++) begin
        chk("R4 request level", 32'(req[p]), 32'(ph[p] == 2));
        chk("R3 write strobe", 32'(we[p]), 32'(!s_dir[p]));
        chk("R3 byte enables", 32'(be[p*4 +: 4]), 32'(s_be[p]));
        chk("R3 address", 32'(addr[p*20 +: 20]), 32'(s_addr[p]));
        chk("R3 write data", wdata[p*32 +: 32], s_dat[p]);
      end
      begin
        logic [31:0] e;
        string tg;
        e = 0; tg = "R2 unmapped read";
        for (int p = 0; p < NP; p++) begin
          if (rd_addr == 8'(4*p)) begin
            e = {c_dir[p], 7'b0, c_be[p], c_addr[p]}; tg = "R2 control readback";
          end
          if (rd_addr == 8'h40 + 8'(4*p)) begin e = m_rd[p]; tg = "R6 captured data"; end
          if (rd_addr == 8'h60 + 8'(4*p)) begin e = 32'(ph[p] != 0); tg = "R7 busy status"; end
        end
        chk(tg, rd_data, e);
      end
    end
  end

  initial begin : rd_rotate
    logic [7:0] lst [16] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h40, 8'h44, 8'h48, 8'h4C,
                             8'h60, 8'h64, 8'h68, 8'h6C, 8'h10, 8'h41, 8'h80, 8'h02};
    forever begin
      for (int i = 0; i < 16; i++) begin
        @(posedge clk); #1;
        rd_addr = lst[i];
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    #1 rst_n = 1'b0;
    repeat (4) tick();
    rst_n = 1'b1;
    repeat (5) tick();
    chk("R1 no request after reset", 32'(req), 32'h0);

    // write on port 0, grant after two waiting cycles
    wr(8'h00, 32'h00F1_2345);
    wr(8'h80, 32'hDEAD_BEEF);
    chk("R3 request raised cycle after launch", 32'(req[0]), 32'h1);
    tick(); tick();
    chk("R4 request held without grant", 32'(req[0]), 32'h1);
    gnt[0] = 1'b1; tick(); gnt[0] = 1'b0;
    chk("R5 request low after grant", 32'(req[0]), 32'h0);
    tick();

    // launch written in the very cycle the grant completes the write
    wr(8'h00, 32'h0031_2300);
    wr(8'h80, 32'h1111_2222);
    gnt[0] = 1'b1;
    wr(8'h80, 32'h3333_4444);
    gnt[0] = 1'b0;
    tick();
    chk("R7 launch in completing cycle ignored", wdata[31:0], 32'h1111_2222);
    chk("R7 launch in completing cycle ignored", 32'(req[0]), 32'h0);

    // launch while busy is ignored
    wr(8'h80, 32'h5555_6666);
    wr(8'h80, 32'h7777_8888);
    tick();
    gnt[0] = 1'b1; tick(); gnt[0] = 1'b0;
    chk("R7 busy launch ignored", wdata[31:0], 32'h5555_6666);

    // read on port 1 with early valid, ctrl rewrite and valid together with grant
    wr(8'h04, 32'h80A0_0040);
    wr(8'h84, 32'h0);
    rdata[63:32] = 32'h1111_1111; valid[1] = 1'b1; tick(); valid[1] = 1'b0;
    wr(8'h04, 32'h0050_0999);
    chk("R8 outstanding address kept", 32'(addr[39:20]), 32'h40);
    chk("R8 outstanding strobe kept", 32'(we[1]), 32'h0);
    gnt[1] = 1'b1; valid[1] = 1'b1; rdata[63:32] = 32'h2222_2222;
    tick();
    gnt[1] = 1'b0; valid[1] = 1'b0;
    tick(); tick();
    rdata[63:32] = 32'hCAFE_F00D; valid[1] = 1'b1; tick(); valid[1] = 1'b0;
    repeat (20) tick();

    // back-pressure on port 2
    fmo[2] = 1'b1;
    wr(8'h08, 32'h000A_BCDE);
    wr(8'h88, 32'h0BAD_CAFE);
    tick(); tick();
    chk("R9 request deferred under back-pressure", 32'(req[2]), 32'h0);
    fmo[2] = 1'b0; tick();
    chk("R9 request after back-pressure clears", 32'(req[2]), 32'h1);
    gnt[2] = 1'b1; tick(); gnt[2] = 1'b0;

    // ports 2 and 3 in flight together, unmapped writes
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h01, 32'hFFFF_FFFF);
    wr(8'h0C, 32'h80F0_0010);
    wr(8'h8C, 32'h0);
    wr(8'h08, 32'h0010_0020);
    wr(8'h88, 32'hA5A5_A5A5);
    chk("R10 port 3 still requesting", 32'(req[3]), 32'h1);
    chk("R10 port 3 address unaffected", 32'(addr[79:60]), 32'h10);
    chk("R10 port 0 untouched", 32'(req[0]), 32'h0);
    gnt = 4'b1100; tick(); gnt = '0;
    tick();
    rdata[127:96] = 32'h0F0F_0F0F; valid[3] = 1'b1; tick(); valid[3] = 1'b0;
    repeat (20) tick();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule